// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel with six counting modes. A host-side register block delivers a mode setting (counting mode, access code and a BCD flag) and then an initial count. The channel decrements once for every clock cycle in which the count-rate enable is high. The counting mode decides what the gate input does, what waveform the output carries, and whether the counter reloads or wraps when it passes zero.

The live count and a status byte are presented continuously so that a separate host-interface block can latch and read them. The channel counts in binary or in four-digit BCD. It does no bus decoding and no read sequencing.

Every control input is sampled on the rising clock edge. Within one cycle the events take effect in this order, highest first: mode write, count write, gate-triggered restart, count tick. An event of lower priority in the same cycle is ignored.

Top module: `ict_channel`

## Requirements
- R1: Reset state. After reset `out_q` is 0, `count_q` is 0 and `status_q` is 0. A count write made before any mode write is ignored, and nothing counts.
- R2: An initial count of 0 stands for the full span. In binary this is 65536 ticks: in mode 0 the output rises on tick 65536. In BCD it is 10000 ticks: in mode 1 the output falls on tick 10000.
- R3: In modes 0, 1, 4 and 5 the counter does not stop at zero. The tick after 0000 shows FFFF in binary or 9999 in BCD, and counting continues.
- R4: In modes 2 and 3 the live count steps N, N-1, ..., 1 and then returns to the initial count N on the next tick, repeating without end.
- R5: Gate behaviour. In modes 0 and 4, gate low freezes the count and gate high lets it run. In modes 1, 2, 3 and 5 the gate level does not suspend counting. Instead, a 0-to-1 change of gate (compared with the previous cycle) restarts the count from N on the next edge.
- R6: Mode 0: `out_q` is low from the count write until N ticks have elapsed. It then goes high and stays high until the next count or mode write.
- R7: Mode 1: `out_q` is high from the count write, or from a restart, until N ticks have elapsed, and low after that.
- R8: Mode 2: `out_q` is high only after the tick that completes a period, and stays high until the following tick. It is never high straight after the count is loaded.
- R9: Mode 3: with p the number of ticks since the period began, `out_q` is high while p < (N+1)/2 (integer division) and low otherwise.
- R10: Modes 4 and 5: `out_q` is high only between the tick on which the elapsed ticks first equal N and the next tick.
- R11: Mode field values 6 and 7 behave as modes 2 and 3, and are reported as 2 and 3 in the status byte.
- R12: Status byte layout: `status_q[7]` = `out_q`, `[6]` = 0, `[5:4]` = stored access code, `[3:1]` = folded mode, `[0]` = BCD flag.
- R13: In BCD mode each 4-bit digit counts down as a decimal digit. A digit at 0 becomes 9 and borrows from the next digit (for example 0100 becomes 0099, and 1000 becomes 0999).
- R14: A mode write disarms the channel. `out_q` goes low and the count holds its value until a count write follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-rate enable; one tick per high cycle |
| gate | input | 1 | Gate input (enable level or restart trigger) |
| cfg_we | input | 1 | Mode write strobe |
| cfg_access | input | 2 | Access code, stored and reported in status |
| cfg_mode | input | 3 | Counting mode 0..7 |
| cfg_bcd | input | 1 | 1 selects BCD counting |
| cnt_we | input | 1 | Initial-count write strobe |
| cnt_val | input | 16 | Initial count |
| out_q | output | 1 | Channel output |
| count_q | output | 16 | Live count |
| status_q | output | 8 | Status byte |

## Verification
The assertions check the following rules on every cycle:
- a disarmed channel holds its output low;
- the folded mode never reports 6 or 7;
- periodic reloads and gate restarts return the count to the initial value;
- the count stays frozen in modes 0 and 4 while the gate is low;
- the counter wraps to all-ones or 9999;
- the strobe of modes 4 and 5 lasts a single tick;
- the mode 0 output stays high once set.

Other behaviour depends on how many ticks have elapsed since the load, and only the bench's scenarios can show it. This covers the exact tick on which each mode's output changes, the mode 3 duty split for odd and even counts, the full 65536-tick and 10000-tick spans of a zero count, and BCD borrow chains. The bench predicts these from a model built on elapsed ticks.

// File: rtl/ict_pkg.sv
`timescale 1ns/1ps
package ict_pkg;

  typedef enum logic [2:0] {
    MD_TERM   = 3'd0,
    MD_RETRIG = 3'd1,
    MD_RATE   = 3'd2,
    MD_SQWAVE = 3'd3,
    MD_SWSTB  = 3'd4,
    MD_HWSTB  = 3'd5
  } ict_mode_e;

  // values 6 and 7 alias the two periodic modes
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic is_periodic(input logic [2:0] m);
    return (m == MD_RATE) || (m == MD_SQWAVE);
  endfunction

  // modes where gate is a level enable instead of a restart trigger
  function automatic logic gate_is_level(input logic [2:0] m);
    return (m == MD_TERM) || (m == MD_SWSTB);
  endfunction

endpackage

// File: rtl/ict_decr.sv
`timescale 1ns/1ps
module ict_decr #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] val,
  input  logic          bcd,
  output logic [CW-1:0] nxt
);
  localparam int NDIG = CW / 4;

  logic [NDIG-1:0] brw;
  logic [CW-1:0]   dec_bcd;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] dg;
    assign dg = val[g*4 +: 4];
    assign dec_bcd[g*4 +: 4] = !brw[g] ? dg : ((dg == 4'd0) ? 4'd9 : dg - 4'd1);
    if (g < NDIG - 1) begin : g_brw
      assign brw[g+1] = brw[g] & (dg == 4'd0);
    end
  end

  assign nxt = bcd ? dec_bcd : (val - CW'(1));
endmodule

// File: rtl/ict_wave.sv
`timescale 1ns/1ps
module ict_wave #(
  parameter int PW = 17
) (
  input  logic [2:0]    mode,
  input  logic          armed,
  input  logic          expired,
  input  logic          pulse,
  input  logic [PW-1:0] phase,
  input  logic [PW-1:0] half,
  output logic          lvl
);
  import ict_pkg::*;

  logic raw;

  always_comb begin
    case (mode)
      MD_TERM:                   raw = expired;
      MD_RETRIG:                 raw = !expired;
      MD_RATE, MD_SWSTB, MD_HWSTB: raw = pulse;
      MD_SQWAVE:                 raw = (phase < half);
      default:                   raw = 1'b0;
    endcase
  end

  assign lvl = armed & raw;
endmodule

// File: rtl/ict_channel.sv
`timescale 1ns/1ps
module ict_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_access,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_bcd,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_val,
  output logic          out_q,
  output logic [CW-1:0] count_q,
  output logic [7:0]    status_q
);
  import ict_pkg::*;

  localparam int NDIG = CW / 4;
  localparam int PW   = CW + 1;

  function automatic logic [PW-1:0] pow10(input int n);
    logic [PW-1:0] r;
    r = PW'(1);
    for (int i = 0; i < n; i++) r = r * PW'(10);
    return r;
  endfunction

  localparam logic [PW-1:0] BIN_SPAN = PW'(1) << CW;
  localparam logic [PW-1:0] BCD_SPAN = pow10(NDIG);

  // number of ticks in one full count of the written value
  function automatic logic [PW-1:0] span_of(input logic [CW-1:0] v, input logic bcd);
    logic [PW-1:0] acc;
    if (bcd) begin
      acc = '0;
      for (int i = NDIG - 1; i >= 0; i--) acc = acc * PW'(10) + PW'(v[i*4 +: 4]);
    end else begin
      acc = PW'(v);
    end
    if (v == '0) acc = bcd ? BCD_SPAN : BIN_SPAN;
    return acc;
  endfunction

  logic [2:0]    mode_r;
  logic [1:0]    acc_r;
  logic          bcd_r, seen_r, armed_r, expired_r, pulse_r, gate_q;
  logic [CW-1:0] init_r, cnt_r, dec_nxt;
  logic [PW-1:0] nspan_r, phase_r, half_w;
  logic          out_w;

  // named internal events
  logic gate_rise, load_evt, restart, gate_ok, tick_go, at_one, reload_evt, expire_evt;

  assign gate_rise  = gate & ~gate_q;
  assign load_evt   = cnt_we & ~cfg_we & seen_r;
  assign restart    = armed_r & gate_rise & ~gate_is_level(mode_r) & ~cfg_we & ~cnt_we;
  assign gate_ok    = gate | ~gate_is_level(mode_r);
  assign tick_go    = armed_r & tick_en & gate_ok & ~cfg_we & ~cnt_we & ~restart;
  assign at_one     = (cnt_r == CW'(1));
  assign reload_evt = tick_go & is_periodic(mode_r) & at_one;
  assign expire_evt = tick_go & ~is_periodic(mode_r) & at_one;
  assign half_w     = (nspan_r + PW'(1)) >> 1;

  ict_decr #(.CW(CW)) u_decr (
    .val (cnt_r),
    .bcd (bcd_r),
    .nxt (dec_nxt)
  );

  ict_wave #(.PW(PW)) u_wave (
    .mode    (mode_r),
    .armed   (armed_r),
    .expired (expired_r),
    .pulse   (pulse_r),
    .phase   (phase_r),
    .half    (half_w),
    .lvl     (out_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r    <= '0;
      acc_r     <= '0;
      bcd_r     <= 1'b0;
      seen_r    <= 1'b0;
      armed_r   <= 1'b0;
      expired_r <= 1'b0;
      pulse_r   <= 1'b0;
      gate_q    <= 1'b0;
      init_r    <= '0;
      cnt_r     <= '0;
      nspan_r   <= '0;
      phase_r   <= '0;
    end else begin
      gate_q <= gate;
      if (cfg_we) begin
        mode_r    <= fold_mode(cfg_mode);
        acc_r     <= cfg_access;
        bcd_r     <= cfg_bcd;
        seen_r    <= 1'b1;
        armed_r   <= 1'b0;
        expired_r <= 1'b0;
        pulse_r   <= 1'b0;
        phase_r   <= '0;
      end else if (load_evt) begin
        armed_r   <= 1'b1;
        init_r    <= cnt_val;
        nspan_r   <= span_of(cnt_val, bcd_r);
        cnt_r     <= cnt_val;
        phase_r   <= '0;
        expired_r <= 1'b0;
        pulse_r   <= 1'b0;
      end else if (restart) begin
        cnt_r     <= init_r;
        phase_r   <= '0;
        expired_r <= 1'b0;
        pulse_r   <= 1'b0;
      end else if (tick_go) begin
        if (reload_evt) begin
          cnt_r   <= init_r;
          phase_r <= '0;
        end else begin
          cnt_r   <= dec_nxt;
          phase_r <= phase_r + PW'(1);
        end
        pulse_r <= at_one & (is_periodic(mode_r) | ~expired_r);
        if (expire_evt) expired_r <= 1'b1;
      end
    end
  end

  assign out_q    = out_w;
  assign count_q  = cnt_r;
  assign status_q = {out_w, 1'b0, acc_r, mode_r, bcd_r};
endmodule

// File: rtl/ict_channel_chk.sv
`timescale 1ns/1ps
module ict_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate,
  input logic          cfg_we,
  input logic          cnt_we,
  input logic          out_q,
  input logic [CW-1:0] count_q,
  input logic [7:0]    status_q,
  input logic          armed,
  input logic [2:0]    mode,
  input logic          bcd,
  input logic [CW-1:0] init,
  input logic          tick_go,
  input logic          reload_evt,
  input logic          restart
);
  localparam int NDIG = CW / 4;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_q); // R14

  AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3:1] < 3'd6); // R11

  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (count_q == $past(init))); // R4

  AST_GATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == $past(init))); // R5

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mode == 3'd0 || mode == 3'd4) && !gate && !cfg_we && !cnt_we)
      |=> $stable(count_q)); // R5

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && mode != 3'd2 && mode != 3'd3 && count_q == '0)
      |=> (count_q == (bcd ? {NDIG{4'h9}} : {CW{1'b1}}))); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && out_q && (mode == 3'd4 || mode == 3'd5)) |=> !out_q); // R10

  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == 3'd0 && out_q && !cfg_we && !cnt_we) |=> out_q); // R6
endmodule

bind ict_channel ict_channel_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate       (gate),
  .cfg_we     (cfg_we),
  .cnt_we     (cnt_we),
  .out_q      (out_q),
  .count_q    (count_q),
  .status_q   (status_q),
  .armed      (armed_r),
  .mode       (mode_r),
  .bcd        (bcd_r),
  .init       (init_r),
  .tick_go    (tick_go),
  .reload_evt (reload_evt),
  .restart    (restart)
);

// File: tb/tb_ict_channel.sv
`timescale 1ns/1ps
module tb_ict_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, gate = 1'b0, cfg_we = 1'b0, cfg_bcd = 1'b0, cnt_we = 1'b0;
  logic [1:0]  cfg_access = '0;
  logic [2:0]  cfg_mode = '0;
  logic [15:0] cnt_val = '0;
  logic        out_q;
  logic [15:0] count_q;
  logic [7:0]  status_q;

  always #2.5 clk = ~clk;

  ict_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .cfg_we(cfg_we), .cfg_access(cfg_access), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .cnt_we(cnt_we), .cnt_val(cnt_val),
    .out_q(out_q), .count_q(count_q), .status_q(status_q)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // reference model: elapsed ticks since load or restart
  bit        m_seen = 0, m_armed = 0, m_bcd = 0, m_gq = 0;
  int        m_mode = 0, m_acc = 0, m_n = 0, m_d = 0;
  logic [15:0] exp_cnt = '0;

  function automatic int bcd_val(input logic [15:0] v);
    return 1000 * int'(v[15:12]) + 100 * int'(v[11:8]) + 10 * int'(v[7:4]) + int'(v[3:0]);
  endfunction

  function automatic logic [15:0] enc(input int v, input bit b);
    int t;
    if (!b) return 16'(v % 65536);
    t = v % 10000;
    return {4'(t / 1000), 4'((t / 100) % 10), 4'((t / 10) % 10), 4'(t % 10)};
  endfunction

  function automatic int span_mod();
    return m_bcd ? 10000 : 65536;
  endfunction

  function automatic bit exp_out();
    if (!m_armed) return 1'b0;
    case (m_mode)
      0: return m_d >= m_n;
      1: return m_d < m_n;
      2: return (m_d % m_n == 0) && (m_d != 0);
      3: return (m_d % m_n) < ((m_n + 1) / 2);
      default: return m_d == m_n;
    endcase
  endfunction

  task automatic model_update();
    bit rise;
    rise = gate && !m_gq;
    m_gq = gate;
    if (cfg_we) begin
      m_mode = int'(cfg_mode);
      if (m_mode > 5) m_mode = m_mode - 4;
      m_acc = int'(cfg_access); m_bcd = cfg_bcd; m_seen = 1; m_armed = 0;
    end else if (cnt_we && m_seen) begin
      m_armed = 1; m_d = 0;
      m_n = m_bcd ? bcd_val(cnt_val) : int'(cnt_val);
      if (m_n == 0) m_n = span_mod();
    end else if (m_armed && rise && m_mode != 0 && m_mode != 4) begin
      m_d = 0;
    end else if (m_armed && tick_en && (gate || (m_mode != 0 && m_mode != 4))) begin
      m_d++;
    end
    if (m_armed) begin
      if (m_mode == 2 || m_mode == 3) exp_cnt = enc(m_n - (m_d % m_n), m_bcd);
      else exp_cnt = enc(((m_n - m_d) % span_mod() + span_mod()) % span_mod(), m_bcd);
    end
  endtask

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit eo;
    eo = exp_out();
    chk("out", 16'(out_q), 16'(eo));
    chk("count", count_q, exp_cnt);
    chk("status", 16'(status_q), 16'({eo, 1'b0, 2'(m_acc), 3'(m_mode), m_bcd}));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_update();
    #1 check_all();
    @(negedge clk);
    cfg_we = 1'b0;
    cnt_we = 1'b0;
  endtask

  task automatic wr_mode(input int acc, input int md, input bit b);
    cfg_access = 2'(acc); cfg_mode = 3'(md); cfg_bcd = b; cfg_we = 1'b1;
    cycle();
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_val = v; cnt_we = 1'b1;
    cycle();
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: state straight after reset
    cur_tag = "R1";
    chk("reset out", 16'(out_q), 16'h0);
    chk("reset count", count_q, 16'h0);
    chk("reset status", 16'(status_q), 16'h0);
    gate = 1'b1;
    wr_cnt(16'd5);
    ticks(4);

    cur_tag = "R6";  wr_mode(3, 0, 0); wr_cnt(16'd5); ticks(9);
    cur_tag = "R7";  wr_mode(3, 1, 0); wr_cnt(16'd4); ticks(7);
    cur_tag = "R8";  wr_mode(3, 2, 0); wr_cnt(16'd3);
    for (int i = 0; i < 12; i++) begin tick_en = (i % 3 != 0); cycle(); end
    cur_tag = "R4";  wr_mode(3, 2, 1); wr_cnt(16'h0012); ticks(30);
    wr_mode(3, 3, 0); wr_cnt(16'd6); ticks(14);
    cur_tag = "R9";  wr_mode(3, 3, 0); wr_cnt(16'd5); ticks(12);
    wr_cnt(16'd4); ticks(10); wr_cnt(16'd1); ticks(3);
    cur_tag = "R10"; wr_mode(3, 4, 0); wr_cnt(16'd3); ticks(8);
    wr_mode(3, 5, 0); wr_cnt(16'd2); ticks(6);
    cur_tag = "R3";  wr_mode(3, 0, 0); wr_cnt(16'd2); ticks(5);
    wr_mode(3, 4, 1); wr_cnt(16'h0001); ticks(4);
    cur_tag = "R5";  wr_mode(3, 0, 0); wr_cnt(16'd6); ticks(2);
    gate = 1'b0; ticks(4); gate = 1'b1; ticks(2);
    wr_mode(3, 5, 0); gate = 1'b0; wr_cnt(16'd4); ticks(2);
    gate = 1'b1; ticks(1); ticks(3);
    wr_mode(3, 1, 0); wr_cnt(16'd5); gate = 1'b0; ticks(3);
    gate = 1'b1; ticks(2);
    wr_mode(3, 2, 0); wr_cnt(16'd7); ticks(3); gate = 1'b0; ticks(1); gate = 1'b1; ticks(4);
    cur_tag = "R11"; wr_mode(1, 6, 0); wr_cnt(16'd2); ticks(5);
    wr_mode(2, 7, 0); wr_cnt(16'd3); ticks(6);
    cur_tag = "R12"; wr_mode(2, 5, 1); wr_cnt(16'h0003); ticks(5);
    cur_tag = "R13"; wr_mode(3, 0, 1); wr_cnt(16'h0100); ticks(3);
    wr_cnt(16'h1000); ticks(2);
    cur_tag = "R14"; wr_mode(3, 3, 0); wr_cnt(16'd8); ticks(3);
    wr_mode(3, 0, 0); ticks(5);
    cur_tag = "R2";  gate = 1'b1; wr_mode(3, 0, 0); wr_cnt(16'h0000); ticks(65537);
    wr_mode(3, 1, 1); wr_cnt(16'h0000); ticks(10001);

    // mixed random traffic over all modes, gates and counts
    cur_tag = "R4 random";
    wr_mode(3, 2, 0); wr_cnt(16'd5);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      tick_en = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 4) == 0) gate = ~gate;
      if (r < 4) begin
        cfg_access = 2'($urandom_range(0, 3));
        cfg_mode = 3'($urandom_range(0, 7));
        cfg_bcd = 1'($urandom_range(0, 1));
        cfg_we = 1'b1;
      end else if (r < 10) begin
        int v;
        v = int'($urandom_range(0, 25));
        cnt_val = m_bcd ? enc(v, 1'b1) : 16'(v);
        cnt_we = 1'b1;
      end
      cycle();
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule